// File: doc/BRIEF.md
# PWM Pulse-Group Sequencer

This block drives the timing inputs of a PWM waveform core. It also contains a small period timer, so the block produces the waveform itself. The block has two ways to run. In counted mode, a single start emits a programmed number of periods and then stops. In queued mode, 16-bit entries wait in an 8-deep FIFO. Each entry describes one group of pulses: a period count, and a flag that selects either the normal compare/maximum pair or a second, shadow pair. The sequencer consumes the entries in order. It returns to idle once the FIFO runs dry.

Software-facing controls appear as plain pins:
- FIFO write and FIFO flush.
- A watermark level for the low-FIFO condition.
- Enables for the two interrupt sources.
- A write-one clear for the sticky group-sent flag.

The block reports the FIFO level with empty and full flags, a 16-bit count of emitted periods, and a combined interrupt line. The compare/maximum pair in use is presented on `cmp_o`/`max_o`, together with a run indication.

Top module: `pwm_group_seq`

## Requirements
- R1: A start with `mode_fifo_i`=0, issued while idle, emits exactly N periods and then drops `run_o`. N is the 14-bit value {`cnt_hi_i`, `cnt_lo_i`}, with the high part in bits 13:8. These periods use `cmp_i`/`max_i`. If N is 0, no period is emitted and only the group-sent flag is set.
- R2: A period lasts `max` clock cycles, and a `max` of 0 is treated as 1. `wave_o` is high for the first min(`cmp`, period length) cycles of each period. While `run_o` is low, `wave_o` stays low.
- R3: In a FIFO entry, bits 13:0 give the group's period count. Bit 14 selects the shadow pair `sh_cmp_i`/`sh_max_i` when it is 1, and the normal pair when it is 0. Bit 15 has no effect.
- R4: A start with `mode_fifo_i`=1 runs the queued entries in write order, one group each, until the FIFO is empty. The sequencer then returns to idle. An entry with a count of 0 emits nothing.
- R5: `grp_sent_o` is set when any group completes. It stays set until a `grp_clr_i` pulse clears it. If a completion and a clear happen in the same cycle, the set wins.
- R6: The FIFO holds 8 entries. `fifo_level_o` gives the entry count, and `fifo_empty_o`/`fifo_full_o` follow it. A write while the FIFO is full is dropped.
- R7: A `fifo_clr_i` pulse empties the FIFO on the next cycle. It takes priority over a write in the same cycle.
- R8: `fifo_low_o` is 1 exactly when `fifo_level_o` is less than `trig_lvl_i`.
- R9: `irq_o` is high when (`grp_sent_o` and `grp_irq_en_i`) or (`fifo_low_o` and `low_irq_en_i`).
- R10: `pulse_cnt_o` counts the periods completed since the last accepted start. It is 0 after reset and wraps at 16 bits.
- R11: The block ignores a start while a sequence is in progress. A queued-mode start with an empty FIFO does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_fifo_i | input | 1 | 0 = counted mode, 1 = queued mode (sampled at start) |
| start_i | input | 1 | Start pulse |
| cnt_lo_i | input | 8 | Counted-mode period count, low part |
| cnt_hi_i | input | 6 | Counted-mode period count, high part |
| cmp_i | input | 16 | Normal compare value |
| max_i | input | 16 | Normal period length |
| sh_cmp_i | input | 16 | Shadow compare value |
| sh_max_i | input | 16 | Shadow period length |
| fifo_wr_i | input | 1 | FIFO write strobe |
| fifo_wdata_i | input | 16 | FIFO entry |
| fifo_clr_i | input | 1 | FIFO flush |
| trig_lvl_i | input | 4 | Low-watermark level |
| grp_irq_en_i | input | 1 | Group-sent interrupt enable |
| low_irq_en_i | input | 1 | Low-FIFO interrupt enable |
| grp_clr_i | input | 1 | Write-one clear of group-sent flag |
| cmp_o | output | 16 | Compare value in use |
| max_o | output | 16 | Period length in use |
| run_o | output | 1 | Waveform core running |
| wave_o | output | 1 | PWM waveform |
| pulse_cnt_o | output | 16 | Completed periods since start |
| fifo_level_o | output | 4 | FIFO entry count |
| fifo_empty_o | output | 1 | FIFO empty |
| fifo_full_o | output | 1 | FIFO full |
| grp_sent_o | output | 1 | Sticky group-sent flag |
| fifo_low_o | output | 1 | FIFO level below watermark |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions check several invariants on every cycle:
- The FIFO level never exceeds the depth, and the FIFO is never both empty and full.
- A write to a full FIFO never raises the level.
- A flush always leaves the FIFO empty.
- The group-sent flag stays set until it is cleared.
- The waveform is low whenever the block is idle.
- The period count grows by at most one per cycle, including when a start arrives mid-run.

Other properties only the bench scenarios can show:
- Each group emits the right number of periods.
- The shadow bit selects the correct pair.
- Bit 15 of an entry is ignored.
- Entries are consumed in order until the FIFO runs dry.

The bench checks these by comparing the total run time and high time against sums computed from the written entries.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_FETCH = 2'd1,
    S_LATCH = 2'd2,
    S_RUN   = 2'd3
  } seq_state_e;

  localparam int ENTRY_W = 16;
endpackage

// File: rtl/pgs_fifo.sv
module pgs_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr,
  input  logic [DW-1:0]    wdata,
  input  logic             rd,
  output logic [DW-1:0]    rdata,
  output logic [LVL_W-1:0] level,
  output logic             empty,
  output logic             full
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_wr, do_rd;

  assign empty = (level == '0);
  assign full  = (level == LVL_W'(DEPTH));
  assign do_wr = wr && !full && !clr;
  assign do_rd = rd && !empty;

  // storage without reset so it can map onto block RAM
  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (do_rd) rdata <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_wr) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_rd) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/pgs_period.sv
module pgs_period #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] cmp,
  input  logic [W-1:0] max,
  output logic         wave,
  output logic         wrap
);
  logic [W-1:0] cnt;
  logic [W-1:0] last;

  assign last = (max == '0) ? '0 : max - 1'b1;
  assign wrap = en && (cnt == last);
  assign wave = en && (cnt < cmp);

  always_ff @(posedge clk) begin
    if (rst || !en || wrap) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pgs_flags.sv
module pgs_flags #(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             grp_set,
  input  logic             grp_clr,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] trig,
  input  logic             grp_en,
  input  logic             low_en,
  output logic             grp_q,
  output logic             low,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (rst)          grp_q <= 1'b0;
    else if (grp_set) grp_q <= 1'b1;
    else if (grp_clr) grp_q <= 1'b0;
  end

  assign low = (level < trig);
  assign irq = (grp_q && grp_en) || (low && low_en);
endmodule

// File: rtl/pwm_group_seq.sv
module pwm_group_seq #(
  parameter int DEPTH  = 8,
  parameter int TW     = 16,
  parameter int LO_W   = 8,
  parameter int HI_W   = 6,
  parameter int PCNT_W = 16,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int CNT_W = LO_W + HI_W,
  localparam int EW    = pgs_pkg::ENTRY_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_fifo_i,
  input  logic              start_i,
  input  logic [LO_W-1:0]   cnt_lo_i,
  input  logic [HI_W-1:0]   cnt_hi_i,
  input  logic [TW-1:0]     cmp_i,
  input  logic [TW-1:0]     max_i,
  input  logic [TW-1:0]     sh_cmp_i,
  input  logic [TW-1:0]     sh_max_i,
  input  logic              fifo_wr_i,
  input  logic [EW-1:0]     fifo_wdata_i,
  input  logic              fifo_clr_i,
  input  logic [LVL_W-1:0]  trig_lvl_i,
  input  logic              grp_irq_en_i,
  input  logic              low_irq_en_i,
  input  logic              grp_clr_i,
  output logic [TW-1:0]     cmp_o,
  output logic [TW-1:0]     max_o,
  output logic              run_o,
  output logic              wave_o,
  output logic [PCNT_W-1:0] pulse_cnt_o,
  output logic [LVL_W-1:0]  fifo_level_o,
  output logic              fifo_empty_o,
  output logic              fifo_full_o,
  output logic              grp_sent_o,
  output logic              fifo_low_o,
  output logic              irq_o
);
  import pgs_pkg::*;

  seq_state_e        state;
  logic [CNT_W-1:0]  remain;
  logic [TW-1:0]     cmp_q, max_q;
  logic              fifo_mode_q;
  logic [PCNT_W-1:0] pcnt;
  logic [EW-1:0]     rd_q;
  logic [CNT_W-1:0]  cnt_total, ent_cnt;
  logic              ent_sh, pop, wrap, grp_done;

  assign cnt_total = {cnt_hi_i, cnt_lo_i};
  assign ent_cnt   = rd_q[CNT_W-1:0];
  assign ent_sh    = rd_q[CNT_W];
  assign pop       = (state == S_FETCH) && !fifo_empty_o;

  pgs_fifo #(.DW(EW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .clr(fifo_clr_i),
    .wr(fifo_wr_i), .wdata(fifo_wdata_i),
    .rd(pop), .rdata(rd_q),
    .level(fifo_level_o), .empty(fifo_empty_o), .full(fifo_full_o)
  );

  pgs_period #(.W(TW)) u_period (
    .clk(clk), .rst(rst), .en(state == S_RUN),
    .cmp(cmp_q), .max(max_q), .wave(wave_o), .wrap(wrap)
  );

  always_comb begin
    grp_done = 1'b0;
    case (state)
      S_IDLE:  grp_done = start_i && !mode_fifo_i && (cnt_total == '0);
      S_LATCH: grp_done = (ent_cnt == '0);
      S_RUN:   grp_done = wrap && (remain == CNT_W'(1));
      default: grp_done = 1'b0;
    endcase
  end

  pgs_flags #(.LVL_W(LVL_W)) u_flags (
    .clk(clk), .rst(rst), .grp_set(grp_done), .grp_clr(grp_clr_i),
    .level(fifo_level_o), .trig(trig_lvl_i),
    .grp_en(grp_irq_en_i), .low_en(low_irq_en_i),
    .grp_q(grp_sent_o), .low(fifo_low_o), .irq(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      remain      <= '0;
      cmp_q       <= '0;
      max_q       <= '0;
      fifo_mode_q <= 1'b0;
      pcnt        <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start_i && !mode_fifo_i) begin
            fifo_mode_q <= 1'b0;
            pcnt        <= '0;
            remain      <= cnt_total;
            cmp_q       <= cmp_i;
            max_q       <= max_i;
            if (cnt_total != '0) state <= S_RUN;
          end else if (start_i && !fifo_empty_o) begin
            fifo_mode_q <= 1'b1;
            pcnt        <= '0;
            state       <= S_FETCH;
          end
        end
        S_FETCH: state <= fifo_empty_o ? S_IDLE : S_LATCH;
        S_LATCH: begin
          remain <= ent_cnt;
          cmp_q  <= ent_sh ? sh_cmp_i : cmp_i;
          max_q  <= ent_sh ? sh_max_i : max_i;
          if (ent_cnt != '0) state <= S_RUN;
          else               state <= fifo_empty_o ? S_IDLE : S_FETCH;
        end
        S_RUN: begin
          if (wrap) begin
            pcnt <= pcnt + 1'b1;
            if (remain == CNT_W'(1))
              state <= (fifo_mode_q && !fifo_empty_o) ? S_FETCH : S_IDLE;
            else
              remain <= remain - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cmp_o       = cmp_q;
  assign max_o       = max_q;
  assign run_o       = (state == S_RUN);
  assign pulse_cnt_o = pcnt;
endmodule

// File: rtl/pgs_checker.sv
module pgs_checker #(
  parameter int DEPTH  = 8,
  parameter int PCNT_W = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              fifo_wr_i,
  input logic              fifo_clr_i,
  input logic              grp_clr_i,
  input logic              run_o,
  input logic              wave_o,
  input logic [PCNT_W-1:0] pulse_cnt_o,
  input logic [LVL_W-1:0]  fifo_level_o,
  input logic              fifo_empty_o,
  input logic              fifo_full_o,
  input logic              grp_sent_o,
  input logic              fifo_low_o,
  input logic              irq_o
);
  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst)
    fifo_level_o <= LVL_W'(DEPTH)); // R6
  AST_EMPTY_FULL_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(fifo_empty_o && fifo_full_o)); // R6
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    fifo_full_o && fifo_wr_i |=> fifo_level_o <= $past(fifo_level_o)); // R6
  AST_CLR_FLUSH: assert property (@(posedge clk) disable iff (rst)
    fifo_clr_i |=> fifo_empty_o); // R7
  AST_GRP_STICKY: assert property (@(posedge clk) disable iff (rst)
    grp_sent_o && !grp_clr_i |=> grp_sent_o); // R5
  AST_IDLE_WAVE: assert property (@(posedge clk) disable iff (rst)
    !run_o |-> !wave_o); // R2
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (grp_sent_o || fifo_low_o)); // R9
  AST_PCNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> (pulse_cnt_o == $past(pulse_cnt_o)) ||
                 (pulse_cnt_o == $past(pulse_cnt_o) + 1'b1)); // R10
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    run_o && start_i |=> (pulse_cnt_o == $past(pulse_cnt_o)) ||
                         (pulse_cnt_o == $past(pulse_cnt_o) + 1'b1)); // R11
endmodule

bind pwm_group_seq pgs_checker #(.DEPTH(DEPTH), .PCNT_W(PCNT_W)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .fifo_wr_i(fifo_wr_i),
  .fifo_clr_i(fifo_clr_i), .grp_clr_i(grp_clr_i), .run_o(run_o),
  .wave_o(wave_o), .pulse_cnt_o(pulse_cnt_o), .fifo_level_o(fifo_level_o),
  .fifo_empty_o(fifo_empty_o), .fifo_full_o(fifo_full_o),
  .grp_sent_o(grp_sent_o), .fifo_low_o(fifo_low_o), .irq_o(irq_o)
);

// File: tb/tb_pwm_group_seq.sv
`timescale 1ns/1ps
module tb_pwm_group_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_fifo_i = 0, start_i = 0, fifo_wr_i = 0, fifo_clr_i = 0;
  logic [7:0]  cnt_lo_i = 0;
  logic [5:0]  cnt_hi_i = 0;
  logic [15:0] cmp_i = 0, max_i = 0, sh_cmp_i = 0, sh_max_i = 0, fifo_wdata_i = 0;
  logic [3:0]  trig_lvl_i = 0;
  logic        grp_irq_en_i = 0, low_irq_en_i = 0, grp_clr_i = 0;
  logic [15:0] cmp_o, max_o, pulse_cnt_o;
  logic        run_o, wave_o, fifo_empty_o, fifo_full_o, grp_sent_o, fifo_low_o, irq_o;
  logic [3:0]  fifo_level_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwm_group_seq dut (
    .clk(clk), .rst(rst), .mode_fifo_i(mode_fifo_i), .start_i(start_i),
    .cnt_lo_i(cnt_lo_i), .cnt_hi_i(cnt_hi_i), .cmp_i(cmp_i), .max_i(max_i),
    .sh_cmp_i(sh_cmp_i), .sh_max_i(sh_max_i), .fifo_wr_i(fifo_wr_i),
    .fifo_wdata_i(fifo_wdata_i), .fifo_clr_i(fifo_clr_i), .trig_lvl_i(trig_lvl_i),
    .grp_irq_en_i(grp_irq_en_i), .low_irq_en_i(low_irq_en_i), .grp_clr_i(grp_clr_i),
    .cmp_o(cmp_o), .max_o(max_o), .run_o(run_o), .wave_o(wave_o),
    .pulse_cnt_o(pulse_cnt_o), .fifo_level_o(fifo_level_o),
    .fifo_empty_o(fifo_empty_o), .fifo_full_o(fifo_full_o),
    .grp_sent_o(grp_sent_o), .fifo_low_o(fifo_low_o), .irq_o(irq_o)
  );

  function automatic int eff(int m);
    return (m == 0) ? 1 : m;
  endfunction
  function automatic int hi_len(int c, int m);
    return (c < eff(m)) ? c : eff(m);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
  endtask

  task automatic push(logic [15:0] d);
    @(negedge clk) begin fifo_wr_i = 1; fifo_wdata_i = d; end
    @(negedge clk) fifo_wr_i = 0;
  endtask

  task automatic clear_grp();
    @(negedge clk) grp_clr_i = 1;
    @(negedge clk) grp_clr_i = 0;
  endtask

  // starts, then counts run and high cycles until idle for 24 cycles
  task automatic measure(output int runc, output int wavec, input int restart_at);
    int idle = 0;
    int i = 0;
    runc = 0; wavec = 0;
    @(negedge clk) start_i = 1;
    while (idle < 24 && i < 50000) begin
      @(negedge clk);
      start_i = (i == restart_at) ? 1'b1 : 1'b0;
      if (run_o) begin idle = 0; runc++; if (wave_o) wavec++; end
      else idle++;
      i++;
    end
    start_i = 0;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int rc, wc, n, c, m, k, er, ew, en;
    logic [15:0] ent;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // reset state (R6, R10)
    chk(fifo_empty_o && !fifo_full_o && fifo_level_o == 0, "R6 reset fifo", fifo_level_o, 0);
    chk(!run_o && !wave_o && !grp_sent_o && !irq_o, "R2 reset idle", run_o, 0);
    chk(pulse_cnt_o == 0, "R10 reset count", pulse_cnt_o, 0);

    // counted mode, random plus one with the high part set
    for (int t = 0; t < 7; t++) begin
      if (t == 6) begin n = 258; c = 2; m = 3; end
      else begin n = 1 + $urandom_range(0, 19); c = $urandom_range(0, 6); m = $urandom_range(0, 6); end
      cnt_lo_i = n[7:0]; cnt_hi_i = n[13:8]; cmp_i = c[15:0]; max_i = m[15:0];
      mode_fifo_i = 0;
      measure(rc, wc, -1);
      chk(rc == n * eff(m), "R1 counted run length", rc, n * eff(m));
      chk(wc == n * hi_len(c, m), "R2 high time", wc, n * hi_len(c, m));
      chk(pulse_cnt_o == n[15:0], "R10 pulse count", pulse_cnt_o, n);
      chk(grp_sent_o, "R5 group flag set", grp_sent_o, 1);
      clear_grp();
      chk(!grp_sent_o, "R5 group flag cleared", grp_sent_o, 0);
    end

    // counted mode with zero periods
    cnt_lo_i = 0; cnt_hi_i = 0;
    measure(rc, wc, -1);
    chk(rc == 0 && grp_sent_o, "R1 zero count", rc, 0);
    chk(pulse_cnt_o == 0, "R10 zero count", pulse_cnt_o, 0);
    clear_grp();

    // start while running ignored
    cnt_lo_i = 10; max_i = 4; cmp_i = 1;
    measure(rc, wc, 15);
    chk(rc == 40 && pulse_cnt_o == 10, "R11 restart ignored", rc, 40);
    clear_grp();

    // queued mode, random entries with shadow and bit 15
    cmp_i = 2; max_i = 3; sh_cmp_i = 4; sh_max_i = 5;
    for (int t = 0; t < 4; t++) begin
      k = (t == 3) ? 10 : 1 + $urandom_range(0, 7);
      er = 0; ew = 0; en = 0;
      for (int j = 0; j < k; j++) begin
        n = $urandom_range(0, 5);
        ent = {1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 14'(n)};
        push(ent);
        if (j < 8) begin
          en += n;
          if (ent[14]) begin er += n * 5; ew += n * 4; end
          else begin er += n * 3; ew += n * 2; end
        end
      end
      @(negedge clk);
      chk(fifo_level_o == ((k > 8) ? 8 : k), "R6 level after writes", fifo_level_o, (k > 8) ? 8 : k);
      chk(fifo_full_o == (k >= 8), "R6 full flag", fifo_full_o, k >= 8);
      mode_fifo_i = 1;
      measure(rc, wc, -1);
      chk(rc == er, "R3 run length by pair", rc, er);
      chk(wc == ew, "R3 high time by pair", wc, ew);
      chk(pulse_cnt_o == en[15:0] && fifo_empty_o, "R4 all entries consumed", pulse_cnt_o, en);
      chk(grp_sent_o, "R5 queued group flag", grp_sent_o, 1);
      clear_grp();
    end

    // flush and empty start
    push(16'd3); push(16'd2); push(16'd1);
    @(negedge clk) begin fifo_clr_i = 1; fifo_wr_i = 1; fifo_wdata_i = 16'd7; end
    @(negedge clk) begin fifo_clr_i = 0; fifo_wr_i = 0; end
    chk(fifo_empty_o && fifo_level_o == 0, "R7 flush", fifo_level_o, 0);
    n = pulse_cnt_o;
    measure(rc, wc, -1);
    chk(rc == 0 && pulse_cnt_o == n[15:0] && !grp_sent_o, "R11 empty start", rc, 0);

    // watermark and interrupt
    for (int t = 0; t < 4; t++) begin
      k = $urandom_range(0, 6);
      c = $urandom_range(0, 8);
      trig_lvl_i = c[3:0];
      for (int j = 0; j < k; j++) push(16'd1);
      @(negedge clk);
      chk(fifo_low_o == (k < c), "R8 low flag", fifo_low_o, k < c);
      low_irq_en_i = 1;
      @(negedge clk);
      chk(irq_o == (k < c), "R9 low irq", irq_o, k < c);
      low_irq_en_i = 0;
      @(negedge clk) fifo_clr_i = 1;
      @(negedge clk) fifo_clr_i = 0;
    end
    trig_lvl_i = 0;
    mode_fifo_i = 0; cnt_lo_i = 2; cnt_hi_i = 0; max_i = 1;
    measure(rc, wc, -1);
    @(negedge clk);
    chk(!irq_o, "R9 group irq disabled", irq_o, 0);
    grp_irq_en_i = 1;
    @(negedge clk);
    chk(irq_o, "R9 group irq enabled", irq_o, 1);
    clear_grp();
    chk(!irq_o, "R9 irq after clear", irq_o, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule